// File: doc/BRIEF.md
# Analog Input Scan Selector

This block chooses, for each sample/convert cycle of a multi-channel converter, which analog input feeds the positive side of the first sample-and-hold channel, which reference feeds its negative side, and which fixed input group and negative reference the other three sample-and-hold channels use. A sequencer pulses `advance` once at the end of every cycle. The block then moves to the next selection.

Two selection sets, A and B, are supplied as inputs. With alternation on, the block uses A on the first cycle and then swaps sets on every advance. With scanning on, the first channel's positive input does not come from the active set. It comes from a pointer that visits the set bits of a 32-bit mask in ascending index order. After the highest set bit, the pointer wraps to the lowest set bit and pulses `seq_end` for one cycle. Alternation can run alongside scanning, and it then still drives the negative and group selections.

Top module: `scan_input_selector`

## Requirements
- R1: After a synchronous active-low reset, `seq_end` is 0 and `use_b` is 0. With scanning off, `ch0_pos` equals `a_pos`.
- R2: With scanning off, `ch0_pos` equals the positive code of the active set: `a_pos` when `use_b` is 0 and `b_pos` when `use_b` is 1.
- R3: When scanning is switched on while the mask is non-zero and has been stable for at least one clock, `ch0_pos` shows the index of the lowest set mask bit.
- R4: While scanning with a stable non-zero mask, each `advance` moves `ch0_pos` to the next higher set mask bit, visible in the cycle after the advance edge.
- R5: An `advance` taken at the highest set mask bit wraps `ch0_pos` to the lowest set bit and raises `seq_end` for exactly one cycle. A single-bit mask wraps on every advance. `seq_end` never rises without an advance in scan mode.
- R6: With scanning on and an all-zero mask, `ch0_pos` follows the active set's positive code and `seq_end` stays 0.
- R7: With `alt_en` high, the first cycle uses set A (`use_b`=0), and every `advance` swaps the active set.
- R8: With `alt_en` low, set A is active. Raising `alt_en` again restarts with set A.
- R9: `ch0_neg` (0 = low reference, 1 = alternate pin), `grp_sel` (0 = first fixed group, 1 = second) and `grp_neg` (0 = low reference, 1 = fixed pin) always come from the active set, including while scanning.
- R10: Without an `advance`, the pointer, the active set and therefore every output hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | Scan mode for the first channel's positive input |
| alt_en | input | 1 | Alternate between sets A and B on each advance |
| scan_mask | input | 32 | Inputs included in the scan, bit i = input i |
| advance | input | 1 | End-of-cycle pulse from the sequencer |
| a_pos | input | 5 | Set A positive input code for the first channel |
| a_neg | input | 1 | Set A negative select for the first channel |
| a_grp | input | 1 | Set A positive group select for channels 1 to 3 |
| a_grp_neg | input | 1 | Set A negative select for channels 1 to 3 |
| b_pos | input | 5 | Set B positive input code for the first channel |
| b_neg | input | 1 | Set B negative select for the first channel |
| b_grp | input | 1 | Set B positive group select for channels 1 to 3 |
| b_grp_neg | input | 1 | Set B negative select for channels 1 to 3 |
| ch0_pos | output | 5 | Positive input code for the first channel |
| ch0_neg | output | 1 | Negative select for the first channel |
| grp_sel | output | 1 | Positive group select for channels 1 to 3 |
| grp_neg | output | 1 | Negative select for channels 1 to 3 |
| use_b | output | 1 | 1 when set B is active |
| seq_end | output | 1 | One-cycle pulse after the scan wraps |

## Verification
A corrupted scan pointer appears on `ch0_pos` in the very cycle after the faulty advance. It shows up either as an index whose mask bit is clear or as a step that does not go upward. A wrong wrap decision appears in the same cycle as a missing or extra `seq_end` pulse. A stuck or mis-toggled set flag appears one cycle after an advance, on `use_b` and on every negative and group output together. Because of this, sparse masks with widely spaced bits and single-bit masks are stepped through a full wrap, both with and without alternation.

// File: rtl/scan_sel_pkg.sv
// Shared types for the scan selector.
// Assumes: the side selections are single-bit choices between two fixed sources.
package scan_sel_pkg;

    // Per-set selections that do not depend on the scan pointer.
    typedef struct packed {
        logic neg0;     // first channel negative: 0 low reference, 1 alternate pin
        logic grp;      // channels 1-3 positive group
        logic grp_neg;  // channels 1-3 negative: 0 low reference, 1 fixed pin
    } side_sel_t;

endpackage

// File: rtl/bit_seek.sv
// Finds the lowest set bit of a mask whose index is at or above a start index.
// Assumes: start may equal WIDTH, which means that no bit qualifies.
module bit_seek #(
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] mask,
    input  logic [IDX_W:0]   start,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Priority search from the top down so that the lowest qualifying bit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(start))) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/scan_pointer.sv
// Holds the scan index and steps it through the set bits of the mask in
// ascending order, wrapping to the lowest set bit with a one-cycle end pulse.
// Assumes: the mask is stable while scanning. When scanning is inactive the
// pointer tracks the lowest set bit, so that a scan starts there.
module scan_pointer #(
    parameter int WIDTH = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [WIDTH-1:0] mask,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr,
    output logic             wrap_pulse
);

    logic             low_found;
    logic [IDX_W-1:0] low_idx;
    logic             up_found;
    logic [IDX_W-1:0] up_idx;
    logic [IDX_W:0]   up_start;

    assign up_start = {1'b0, ptr} + 1'b1;

    bit_seek #(.WIDTH(WIDTH)) i_low (
        .mask  (mask),
        .start ('0),
        .found (low_found),
        .idx   (low_idx)
    );

    bit_seek #(.WIDTH(WIDTH)) i_up (
        .mask  (mask),
        .start (up_start),
        .found (up_found),
        .idx   (up_idx)
    );

    // Pointer update: track the lowest bit when idle, step or wrap on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr        <= '0;
            wrap_pulse <= 1'b0;
        end else if (!active) begin
            ptr        <= low_idx;
            wrap_pulse <= 1'b0;
        end else if (advance && up_found) begin
            ptr        <= up_idx;
            wrap_pulse <= 1'b0;
        end else if (advance) begin
            ptr        <= low_idx;
            wrap_pulse <= low_found;
        end else begin
            wrap_pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/ab_alternator.sv
// Keeps the A/B set flag and selects the active set's codes.
// Assumes: the flag is held at A whenever alternation is off, so that
// alternation always restarts on A.
module ab_alternator #(
    parameter int POS_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alt_en,
    input  logic                    advance,
    input  logic [POS_W-1:0]        pos_a,
    input  logic [POS_W-1:0]        pos_b,
    input  scan_sel_pkg::side_sel_t side_a,
    input  scan_sel_pkg::side_sel_t side_b,
    output logic                    sel_b,
    output logic [POS_W-1:0]        pos_act,
    output scan_sel_pkg::side_sel_t side_act
);

    logic flag_b;

    // Set flag: cleared when alternation is off, toggled on each advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !alt_en) begin
            flag_b <= 1'b0;
        end else if (advance) begin
            flag_b <= ~flag_b;
        end
    end

    // Active-set multiplexer; set A is forced while alternation is off.
    always_comb begin
        sel_b    = alt_en & flag_b;
        pos_act  = sel_b ? pos_b  : pos_a;
        side_act = sel_b ? side_b : side_a;
    end

endmodule

// File: rtl/scan_input_selector.sv
// Top level: combines the scan pointer and the A/B alternator into the
// per-cycle input selections for the sample-and-hold channels.
// Assumes: advance is a one-cycle pulse; the mask is changed only while
// scanning is off or together with a restart of the scan.
module scan_input_selector #(
    parameter int NUM_INPUTS = 32,
    localparam int SEL_W = $clog2(NUM_INPUTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scan_en,
    input  logic                  alt_en,
    input  logic [NUM_INPUTS-1:0] scan_mask,
    input  logic                  advance,
    input  logic [SEL_W-1:0]      a_pos,
    input  logic                  a_neg,
    input  logic                  a_grp,
    input  logic                  a_grp_neg,
    input  logic [SEL_W-1:0]      b_pos,
    input  logic                  b_neg,
    input  logic                  b_grp,
    input  logic                  b_grp_neg,
    output logic [SEL_W-1:0]      ch0_pos,
    output logic                  ch0_neg,
    output logic                  grp_sel,
    output logic                  grp_neg,
    output logic                  use_b,
    output logic                  seq_end
);

    import scan_sel_pkg::*;

    side_sel_t        side_a;
    side_sel_t        side_b;
    side_sel_t        side_act;
    logic [SEL_W-1:0] pos_act;
    logic [SEL_W-1:0] scan_idx;
    logic             scan_live;

    // Pack the per-set side selections.
    always_comb begin
        side_a = '{neg0: a_neg, grp: a_grp, grp_neg: a_grp_neg};
        side_b = '{neg0: b_neg, grp: b_grp, grp_neg: b_grp_neg};
    end

    assign scan_live = scan_en & (|scan_mask);

    scan_pointer #(.WIDTH(NUM_INPUTS)) i_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (scan_live),
        .mask       (scan_mask),
        .advance    (advance),
        .ptr        (scan_idx),
        .wrap_pulse (seq_end)
    );

    ab_alternator #(.POS_W(SEL_W)) i_alt (
        .clk      (clk),
        .rst_n    (rst_n),
        .alt_en   (alt_en),
        .advance  (advance),
        .pos_a    (a_pos),
        .pos_b    (b_pos),
        .side_a   (side_a),
        .side_b   (side_b),
        .sel_b    (use_b),
        .pos_act  (pos_act),
        .side_act (side_act)
    );

    // Output steering: the scan pointer overrides only the first channel's positive code.
    always_comb begin
        ch0_pos = scan_live ? scan_idx : pos_act;
        ch0_neg = side_act.neg0;
        grp_sel = side_act.grp;
        grp_neg = side_act.grp_neg;
    end

endmodule

// File: rtl/scan_input_selector_chk.sv
// Property checker bound to the selector; observes ports only.
module scan_input_selector_chk #(
    parameter int NUM_INPUTS = 32,
    localparam int SEL_W = $clog2(NUM_INPUTS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scan_en,
    input logic                  alt_en,
    input logic [NUM_INPUTS-1:0] scan_mask,
    input logic                  advance,
    input logic [SEL_W-1:0]      ch0_pos,
    input logic                  use_b,
    input logic                  seq_end
);

    // R4: a steady scan only points at inputs that are in the mask.
    a_r4_ptr_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && $past(scan_en) && $past(rst_n) && $past(|scan_mask) && $stable(scan_mask))
        |-> scan_mask[ch0_pos]);

    // R4: a non-wrapping advance moves strictly upward.
    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && $past(scan_en) && $past(advance) && $past(rst_n) && !seq_end
         && $past(|scan_mask) && $stable(scan_mask))
        |-> ch0_pos > $past(ch0_pos));

    // R5: the end pulse follows an advance made in scan mode.
    a_r5_end_needs_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_end && $past(rst_n)) |-> ($past(advance) && $past(scan_en)));

    // R6: an empty mask never produces an end pulse.
    a_r6_empty_no_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(scan_mask) == '0) |-> !seq_end);

    // R7: each advance under alternation swaps the active set.
    a_r7_alt_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_en && $past(alt_en) && $past(advance) && $past(rst_n)) |-> use_b != $past(use_b));

    // R8: with alternation off the active set is A.
    a_r8_alt_off_a: assert property (@(posedge clk) disable iff (!rst_n)
        !alt_en |-> !use_b);

    // R10: without an advance the set flag holds.
    a_r10_hold_set: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_en && $past(alt_en) && !$past(advance) && $past(rst_n)) |-> $stable(use_b));

endmodule

bind scan_input_selector scan_input_selector_chk i_chk (.*);

// File: tb/test_scan_input_selector.sv
`timescale 1ns/1ps
module test_scan_input_selector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_en = 1'b0;
    logic        alt_en = 1'b0;
    logic [31:0] scan_mask = '0;
    logic        advance = 1'b0;
    logic [4:0]  a_pos = 5'd7;
    logic        a_neg = 1'b0;
    logic        a_grp = 1'b0;
    logic        a_grp_neg = 1'b1;
    logic [4:0]  b_pos = 5'd12;
    logic        b_neg = 1'b1;
    logic        b_grp = 1'b1;
    logic        b_grp_neg = 1'b0;
    logic [4:0]  ch0_pos;
    logic        ch0_neg;
    logic        grp_sel;
    logic        grp_neg;
    logic        use_b;
    logic        seq_end;

    int checks = 0;
    int errors = 0;
    bit reported = 0;

    scan_input_selector i_scan_input_selector (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic step();
        advance = 1'b1;
        @(negedge clk);
        advance = 1'b0;
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R1 seq_end", seq_end, 0);
        chk("R1 use_b", use_b, 0);
        chk("R1 ch0_pos", ch0_pos, 7);
    endtask

    task automatic t_static();
        chk("R2 pos A", ch0_pos, 7);
        chk("R9 neg A", ch0_neg, 0);
        chk("R9 grp A", grp_sel, 0);
        chk("R9 grp_neg A", grp_neg, 1);
        step();
        chk("R2 pos after advance", ch0_pos, 7);
        chk("R5 no end when scan off", seq_end, 0);
    endtask

    task automatic t_scan_sparse();
        scan_mask = 32'h8000_0402;
        idle(1);
        scan_en = 1'b1;
        idle(1);
        chk("R3 start lowest", ch0_pos, 1);
        step();
        chk("R4 next 10", ch0_pos, 10);
        chk("R5 no end mid", seq_end, 0);
        step();
        chk("R4 next 31", ch0_pos, 31);
        step();
        chk("R5 wrap to 1", ch0_pos, 1);
        chk("R5 end pulse", seq_end, 1);
        idle(1);
        chk("R5 end one cycle", seq_end, 0);
        chk("R10 hold", ch0_pos, 1);
        scan_en = 1'b0;
        idle(1);
    endtask

    task automatic t_single();
        scan_mask = 32'h0000_0020;
        idle(1);
        scan_en = 1'b1;
        idle(1);
        chk("R3 single start", ch0_pos, 5);
        step();
        chk("R5 single wrap pos", ch0_pos, 5);
        chk("R5 single wrap end", seq_end, 1);
        step();
        chk("R5 single wrap again", seq_end, 1);
        scan_en = 1'b0;
        idle(1);
    endtask

    task automatic t_zero();
        scan_mask = '0;
        idle(1);
        scan_en = 1'b1;
        idle(1);
        chk("R6 zero pos", ch0_pos, 7);
        step();
        chk("R6 zero no end", seq_end, 0);
        chk("R6 zero pos after", ch0_pos, 7);
        scan_en = 1'b0;
        idle(1);
    endtask

    task automatic t_alt();
        alt_en = 1'b1;
        idle(1);
        chk("R7 starts A", use_b, 0);
        step();
        chk("R7 swap to B", use_b, 1);
        chk("R2 pos B", ch0_pos, 12);
        chk("R9 neg B", ch0_neg, 1);
        chk("R9 grp B", grp_sel, 1);
        chk("R9 grp_neg B", grp_neg, 0);
        idle(3);
        chk("R10 set held", use_b, 1);
        step();
        chk("R7 back to A", use_b, 0);
        step();
        alt_en = 1'b0;
        idle(1);
        chk("R8 off gives A", use_b, 0);
        chk("R8 off pos A", ch0_pos, 7);
        alt_en = 1'b1;
        idle(1);
        chk("R8 restart A", use_b, 0);
        alt_en = 1'b0;
        idle(1);
    endtask

    task automatic t_combined();
        scan_mask = 32'h8000_0402;
        idle(1);
        scan_en = 1'b1;
        alt_en = 1'b1;
        idle(1);
        chk("R3 comb start", ch0_pos, 1);
        step();
        chk("R4 comb pos 10", ch0_pos, 10);
        chk("R9 comb neg from B", ch0_neg, 1);
        step();
        chk("R4 comb pos 31", ch0_pos, 31);
        chk("R9 comb neg from A", ch0_neg, 0);
        step();
        chk("R5 comb wrap", ch0_pos, 1);
        chk("R5 comb end", seq_end, 1);
        chk("R7 comb set B", use_b, 1);
        scan_en = 1'b0;
        alt_en = 1'b0;
        idle(1);
    endtask

    initial begin
        idle(1);
        t_reset();
        t_static();
        t_scan_sparse();
        t_single();
        t_zero();
        t_alt();
        t_combined();
        report();
    end

    initial begin
        #(8 * 5000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

endmodule